// File: doc/BRIEF.md
# Floating-Point Register Stack with Tags

This block keeps the eight 80-bit extended-precision data registers of a floating-point unit. The registers form a circular stack. A 3-bit top pointer selects the stack top, and each physical register carries a 2-bit tag. The tag says whether the register holds a valid number, a zero, an infinity or NaN, or nothing. A sequencer upstream drives one micro-operation per cycle on a command port. The supported operations are:

- push a value
- copy out ST(i)
- copy out ST and pop it
- swap ST with ST(i)
- overwrite ST(i)
- mark ST(i) empty
- step the top pointer up or down
- reinitialise the stack

The block never interprets the data arithmetically. Only the tag classifier looks at the exponent and significand fields.

Stack references are relative: ST(i) is physical register (top + i) mod 8. Register k's tag is visible at all times in the 16-bit tag word. A push onto an occupied slot raises the overflow pulse. A read, pop or exchange that touches an empty slot raises the underflow pulse. Either pulse also drives the invalid-operation output.

Control is a two-state machine:

- CLEAR: the stack is being wiped and commands are ignored. CLEAR always moves to READY on the next cycle (transition clear_done).
- READY: commands are accepted. READY moves to CLEAR when an initialise command is accepted (transition init_cmd) and otherwise stays in READY (transition hold).

Reset enters CLEAR.

Top module: `fpstack_regs`

## Requirements
- R1: After reset, and after an accepted initialise command (op 9), the block spends exactly one cycle in CLEAR with `cmd_ready` low. It then leaves `top_ptr` = 0, all tags at 11 (`tag_word` = 16'hFFFF), and `cmd_ready` high.
- R2: Relative index i addresses physical register (top_ptr + i) mod 8, wrapping past 7 to 0.
- R3: Push (op 1) onto an empty slot first lowers `top_ptr` by one, then writes the value at the new top. Register k's tag appears in `tag_word[2k+1:2k]`.
- R4: A written value's tag is classified from its fields: exponent bits [78:64], significand bits [63:0], sign bit 79 ignored.
  - Exponent all ones gives 10.
  - Exponent and significand both zero give 01.
  - Anything else, including a nonzero significand with a zero exponent, gives 00.
- R5: Push onto a non-empty slot pulses `stk_ovf` for one cycle and leaves `top_ptr`, data and tags unchanged.
- R6: Store (op 2) of a non-empty ST(i) gives `res_valid` high one cycle later, with that register's data on `res_data` and its tag on `res_tag`. It changes no state.
- R7: Store-and-pop (op 3) of a non-empty ST outputs it as in R6, sets its tag to 11 and raises `top_ptr` by one.
- R8: Store, store-and-pop or exchange that touches an empty register pulses `stk_unf`. It leaves `res_valid` low and changes no state.
- R9: Exchange (op 4) swaps both the data and the tags of ST and ST(i).
- R10: Free (op 5) sets the tag of ST(i) to 11 and leaves `top_ptr` unchanged.
- R11: Increment (op 6) and decrement (op 7) change `top_ptr` by +1 or −1 modulo 8. They move no data and change no tag.
- R12: Write (op 8) overwrites ST(i) with `cmd_data` and sets its tag by R4 without moving `top_ptr`. Op 0 and undefined codes do nothing.
- R13: `stk_invalid` is high exactly when `stk_ovf` or `stk_unf` is high, and no command raises both.
- R14: A command presented while `cmd_ready` is low is ignored: no state change and no result or flag pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code (see requirements) |
| cmd_idx | input | 3 | Relative index i for ST(i) |
| cmd_data | input | 80 | Value for push and write |
| cmd_ready | output | 1 | High in READY, low in CLEAR |
| res_valid | output | 1 | Result of a store or pop is on `res_data` |
| res_data | output | 80 | Value copied out |
| res_tag | output | 2 | Tag of the value copied out |
| stk_ovf | output | 1 | Stack overflow pulse |
| stk_unf | output | 1 | Stack underflow pulse |
| stk_invalid | output | 1 | Invalid-operation pulse (overflow or underflow) |
| top_ptr | output | 3 | Physical index of ST |
| tag_word | output | 16 | All eight tags, register k at bits 2k+1:2k |

## Verification
The assertions assume that `cmd_valid` is the only qualifier of a command. They also assume that `cmd_op` and `cmd_idx` are known and steady around each rising edge while `cmd_valid` is high. The stimulus changes every input on the falling edge and holds a command for exactly one cycle. Between commands it returns `cmd_valid` to low. It issues only defined operation codes, and it offers one command during CLEAR on purpose, to exercise R14.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_t;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_PUSH  = 4'd1,
        OP_STORE = 4'd2,
        OP_POPST = 4'd3,
        OP_XCHG  = 4'd4,
        OP_FREE  = 4'd5,
        OP_INCP  = 4'd6,
        OP_DECP  = 4'd7,
        OP_WRITE = 4'd8,
        OP_INIT  = 4'd9
    } op_t;

    typedef enum logic {
        S_CLEAR = 1'b0,
        S_READY = 1'b1
    } state_t;

endpackage

// File: rtl/fpstk_tagclass.sv
module fpstk_tagclass
    import fpstk_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W+SIG_W:0] value,
    output tag_t                 tag
);
    logic [EXP_W-1:0] expo;
    logic [SIG_W-1:0] sig;

    assign expo = value[EXP_W+SIG_W-1:SIG_W];
    assign sig  = value[SIG_W-1:0];

    // R4: classification from the exponent and significand fields only
    always_comb begin
        if (&expo)
            tag = TAG_SPECIAL;
        else if (expo == '0 && sig == '0)
            tag = TAG_ZERO;
        else
            tag = TAG_VALID;
    end
endmodule

// File: rtl/fpstk_relmap.sv
module fpstk_relmap #(
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0] base,
    input  logic [PTR_W-1:0] offset,
    output logic [PTR_W-1:0] phys
);
    // R2: modulo wrap through the natural width of the pointer
    assign phys = base + offset;
endmodule

// File: rtl/fpstack_regs.sv
module fpstack_regs
    import fpstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int WIDTH = 1 + EXP_W + SIG_W,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [3:0]         cmd_op,
    input  logic [PTR_W-1:0]   cmd_idx,
    input  logic [WIDTH-1:0]   cmd_data,
    output logic               cmd_ready,
    output logic               res_valid,
    output logic [WIDTH-1:0]   res_data,
    output logic [1:0]         res_tag,
    output logic               stk_ovf,
    output logic               stk_unf,
    output logic               stk_invalid,
    output logic [PTR_W-1:0]   top_ptr,
    output logic [2*DEPTH-1:0] tag_word
);
    localparam logic [PTR_W-1:0] BELOW = PTR_W'(DEPTH - 1);

    state_t           state_q, state_d;
    logic [PTR_W-1:0] top_q;
    tag_t             tag_q  [DEPTH];
    logic [WIDTH-1:0] data_q [DEPTH];

    op_t              op;
    logic             fire;
    logic [PTR_W-1:0] p_sel, p_push, rd_phys;
    tag_t             cls_tag;

    logic push_ok, ovf_d, unf_d, rd_ok, pop_ok, xchg_ok;
    logic free_en, wr_en, inc_en, dec_en, init_req;

    assign op   = op_t'(cmd_op);
    assign fire = cmd_valid && (state_q == S_READY);

    fpstk_relmap #(.PTR_W(PTR_W)) u_map_sel (
        .base(top_q), .offset(cmd_idx), .phys(p_sel));

    fpstk_relmap #(.PTR_W(PTR_W)) u_map_push (
        .base(top_q), .offset(BELOW), .phys(p_push));

    fpstk_tagclass #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_class (
        .value(cmd_data), .tag(cls_tag));

    assign rd_phys = (op == OP_POPST) ? top_q : p_sel;

    // command decode
    always_comb begin
        push_ok  = 1'b0; ovf_d   = 1'b0; unf_d   = 1'b0;
        rd_ok    = 1'b0; pop_ok  = 1'b0; xchg_ok = 1'b0;
        free_en  = 1'b0; wr_en   = 1'b0; inc_en  = 1'b0;
        dec_en   = 1'b0; init_req = 1'b0;
        if (fire) begin
            unique case (op)
                OP_PUSH:  if (tag_q[p_push] == TAG_EMPTY) push_ok = 1'b1;
                          else ovf_d = 1'b1;
                OP_STORE: if (tag_q[p_sel] == TAG_EMPTY) unf_d = 1'b1;
                          else rd_ok = 1'b1;
                OP_POPST: if (tag_q[top_q] == TAG_EMPTY) unf_d = 1'b1;
                          else pop_ok = 1'b1;
                OP_XCHG:  if (tag_q[top_q] == TAG_EMPTY || tag_q[p_sel] == TAG_EMPTY)
                              unf_d = 1'b1;
                          else xchg_ok = 1'b1;
                OP_FREE:  free_en  = 1'b1;
                OP_INCP:  inc_en   = 1'b1;
                OP_DECP:  dec_en   = 1'b1;
                OP_WRITE: wr_en    = 1'b1;
                OP_INIT:  init_req = 1'b1;
                default:  ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            S_CLEAR: state_d = S_READY;
            S_READY: state_d = init_req ? S_CLEAR : S_READY;
            default: state_d = S_CLEAR;
        endcase
    end

    // pointer, tags and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q     <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_tag   <= TAG_EMPTY;
            stk_ovf   <= 1'b0;
            stk_unf   <= 1'b0;
            for (int k = 0; k < DEPTH; k++) tag_q[k] <= TAG_EMPTY;
        end else begin
            res_valid <= rd_ok || pop_ok;
            stk_ovf   <= ovf_d;
            stk_unf   <= unf_d;
            if (rd_ok || pop_ok) begin
                res_data <= data_q[rd_phys];
                res_tag  <= tag_q[rd_phys];
            end
            if (state_q == S_CLEAR) begin
                top_q <= '0;
                for (int k = 0; k < DEPTH; k++) tag_q[k] <= TAG_EMPTY;
            end else begin
                if (push_ok) begin
                    top_q         <= p_push;
                    tag_q[p_push] <= cls_tag;
                end
                if (pop_ok) begin
                    tag_q[top_q] <= TAG_EMPTY;
                    top_q        <= top_q + 1'b1;
                end
                if (xchg_ok) begin
                    tag_q[p_sel] <= tag_q[top_q];
                    tag_q[top_q] <= tag_q[p_sel];
                end
                if (free_en) tag_q[p_sel] <= TAG_EMPTY;
                if (wr_en)   tag_q[p_sel] <= cls_tag;
                if (inc_en)  top_q <= top_q + 1'b1;
                if (dec_en)  top_q <= top_q - 1'b1;
            end
        end
    end

    // data array, no reset needed: the tags gate every read
    always_ff @(posedge clk) begin
        if (push_ok) data_q[p_push] <= cmd_data;
        if (wr_en)   data_q[p_sel]  <= cmd_data;
        if (xchg_ok) begin
            data_q[p_sel] <= data_q[top_q];
            data_q[top_q] <= data_q[p_sel];
        end
    end

    assign cmd_ready   = (state_q == S_READY);
    assign top_ptr     = top_q;
    assign stk_invalid = stk_ovf || stk_unf;

    for (genvar k = 0; k < DEPTH; k++) begin : g_tagword
        assign tag_word[2*k +: 2] = tag_q[k];
    end
endmodule

// File: rtl/fpstk_checker.sv
module fpstk_checker #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [3:0]         cmd_op,
    input logic [PTR_W-1:0]   cmd_idx,
    input logic               cmd_ready,
    input logic [PTR_W-1:0]   top_ptr,
    input logic [2*DEPTH-1:0] tag_word,
    input logic               stk_ovf,
    input logic               stk_unf,
    input logic               res_valid
);
    logic             fire;
    logic [PTR_W-1:0] below_top;
    logic [1:0]       tag_top, tag_below;

    assign fire      = cmd_valid && cmd_ready;
    assign below_top = top_ptr - 1'b1;
    assign tag_top   = tag_word[2*top_ptr +: 2];
    assign tag_below = tag_word[2*below_top +: 2];

    // R1
    clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> (tag_word == '1 && top_ptr == '0));

    // R3
    push_moves_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 4'd1 && tag_below == 2'b11)
        |=> (top_ptr == $past(below_top) && tag_top != 2'b11 && !stk_ovf));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 4'd1 && tag_below != 2'b11)
        |=> (stk_ovf && $stable(top_ptr) && $stable(tag_word)));

    // R7
    pop_raises_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 4'd3 && tag_top != 2'b11)
        |=> (res_valid && top_ptr == $past(top_ptr) + 1'b1));

    // R8
    pop_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 4'd3 && tag_top == 2'b11)
        |=> (stk_unf && !res_valid && $stable(top_ptr) && $stable(tag_word)));

    // R11
    inc_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 4'd6)
        |=> (top_ptr == $past(top_ptr) + 1'b1 && $stable(tag_word)));

    // R13
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_ovf && stk_unf));

    // R14
    ignore_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (!stk_ovf && !stk_unf && !res_valid));
endmodule

bind fpstack_regs fpstk_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_ready(cmd_ready), .top_ptr(top_ptr),
    .tag_word(tag_word), .stk_ovf(stk_ovf), .stk_unf(stk_unf),
    .res_valid(res_valid));

// File: tb/fpstack_regs_test.sv
module fpstack_regs_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [79:0] V_A   = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_Z   = {1'b1, 15'h0000, 64'h0};
    localparam logic [79:0] V_INF = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_NAN = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};
    localparam logic [79:0] V_DEN = {1'b0, 15'h0000, 64'h1};
    localparam logic [79:0] V_B   = {1'b0, 15'h4005, 64'hC8A0_0000_0000_0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [2:0]  cmd_idx = 3'd0;
    logic [79:0] cmd_data = '0;
    logic        cmd_ready, res_valid, stk_ovf, stk_unf, stk_invalid;
    logic [79:0] res_data;
    logic [1:0]  res_tag;
    logic [2:0]  top_ptr;
    logic [15:0] tag_word;

    int checks = 0;
    int errors = 0;

    fpstack_regs uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf), .stk_invalid(stk_invalid),
        .top_ptr(top_ptr), .tag_word(tag_word));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic do_cmd(input logic [3:0] op, input logic [2:0] idx,
                          input logic [79:0] data);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 4'd0; cmd_idx = 3'd0; cmd_data = '0;
    endtask

    task automatic do_init();
        do_cmd(4'd9, 3'd0, '0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "ready during clear", 80'(cmd_ready), 80'd0);
        @(negedge clk);
        check("R1", "ready after clear", 80'(cmd_ready), 80'd1);
        check("R1", "top after reset", 80'(top_ptr), 80'd0);
        check("R1", "tag word after reset", 80'(tag_word), 80'hFFFF);
    endtask

    task automatic t_push();
        do_cmd(4'd1, 3'd0, V_A);
        check("R3", "top after push 1", 80'(top_ptr), 80'd7);
        check("R3", "tags after push 1", 80'(tag_word), 80'h3FFF);
        do_cmd(4'd1, 3'd0, V_Z);
        check("R4", "tags after zero push", 80'(tag_word), 80'h1FFF);
        do_cmd(4'd1, 3'd0, V_INF);
        check("R3", "top after push 3", 80'(top_ptr), 80'd5);
        check("R4", "tags after inf push", 80'(tag_word), 80'h1BFF);
    endtask

    task automatic t_store();
        do_cmd(4'd2, 3'd0, '0);
        check("R6", "store ST valid", 80'(res_valid), 80'd1);
        check("R6", "store ST data", res_data, V_INF);
        check("R6", "store ST tag", 80'(res_tag), 80'd2);
        do_cmd(4'd2, 3'd2, '0);
        check("R6", "store ST(2) data", res_data, V_A);
        check("R6", "store keeps top", 80'(top_ptr), 80'd5);
        do_cmd(4'd2, 3'd3, '0);
        check("R8", "store empty unf", 80'(stk_unf), 80'd1);
        check("R8", "store empty no result", 80'(res_valid), 80'd0);
        check("R13", "invalid on unf", 80'(stk_invalid), 80'd1);
    endtask

    task automatic t_xchg_pop();
        do_cmd(4'd4, 3'd2, '0);
        check("R9", "tags after exchange", 80'(tag_word), 80'h93FF);
        do_cmd(4'd2, 3'd0, '0);
        check("R9", "ST after exchange", res_data, V_A);
        do_cmd(4'd3, 3'd0, '0);
        check("R7", "pop data", res_data, V_A);
        check("R7", "pop valid", 80'(res_valid), 80'd1);
        check("R7", "pop top", 80'(top_ptr), 80'd6);
        check("R7", "pop tags", 80'(tag_word), 80'h9FFF);
    endtask

    task automatic t_write_free_step();
        do_cmd(4'd8, 3'd1, V_B);
        check("R12", "write tags", 80'(tag_word), 80'h1FFF);
        check("R12", "write keeps top", 80'(top_ptr), 80'd6);
        do_cmd(4'd5, 3'd0, '0);
        check("R10", "free tags", 80'(tag_word), 80'h3FFF);
        check("R10", "free keeps top", 80'(top_ptr), 80'd6);
        do_cmd(4'd2, 3'd0, '0);
        check("R8", "read of freed unf", 80'(stk_unf), 80'd1);
        do_cmd(4'd7, 3'd0, '0);
        check("R11", "decrement", 80'(top_ptr), 80'd5);
        do_cmd(4'd6, 3'd0, '0);
        do_cmd(4'd6, 3'd0, '0);
        check("R11", "increment twice", 80'(top_ptr), 80'd7);
        check("R11", "step keeps tags", 80'(tag_word), 80'h3FFF);
        do_cmd(4'd2, 3'd0, '0);
        check("R11", "data not moved", res_data, V_B);
        do_cmd(4'd0, 3'd0, V_A);
        check("R12", "nop keeps tags", 80'(tag_word), 80'h3FFF);
    endtask

    task automatic t_classify();
        do_init();
        do_cmd(4'd1, 3'd0, V_NAN);
        check("R4", "nan tag", 80'(tag_word), 80'hBFFF);
        do_cmd(4'd1, 3'd0, V_DEN);
        check("R4", "denormal tag", 80'(tag_word), 80'h8FFF);
    endtask

    task automatic t_wrap();
        do_init();
        check("R1", "init top", 80'(top_ptr), 80'd0);
        check("R1", "init tags", 80'(tag_word), 80'hFFFF);
        do_cmd(4'd7, 3'd0, '0);
        check("R2", "decrement wraps", 80'(top_ptr), 80'd7);
        do_cmd(4'd8, 3'd1, V_B);
        check("R2", "ST(1) wraps to reg 0", 80'(tag_word), 80'hFFFC);
        do_cmd(4'd2, 3'd1, '0);
        check("R2", "read ST(1) wrapped", res_data, V_B);
    endtask

    task automatic t_overflow();
        do_init();
        for (int k = 0; k < 8; k++) do_cmd(4'd1, 3'd0, V_B + 80'(k));
        check("R3", "full stack top", 80'(top_ptr), 80'd0);
        check("R3", "full stack tags", 80'(tag_word), 80'h0000);
        do_cmd(4'd1, 3'd0, V_A);
        check("R5", "overflow flag", 80'(stk_ovf), 80'd1);
        check("R13", "invalid on ovf", 80'(stk_invalid), 80'd1);
        check("R5", "overflow keeps top", 80'(top_ptr), 80'd0);
        check("R5", "overflow keeps tags", 80'(tag_word), 80'h0000);
        do_cmd(4'd2, 3'd0, '0);
        check("R5", "overflow keeps data", res_data, V_B + 80'd7);
        check("R13", "flags drop", 80'(stk_invalid), 80'd0);
    endtask

    task automatic t_underflow();
        do_init();
        do_cmd(4'd3, 3'd0, '0);
        check("R8", "pop empty unf", 80'(stk_unf), 80'd1);
        check("R8", "pop empty no result", 80'(res_valid), 80'd0);
        check("R8", "pop empty top", 80'(top_ptr), 80'd0);
        do_cmd(4'd1, 3'd0, V_A);
        do_cmd(4'd4, 3'd1, '0);
        check("R8", "exchange with empty unf", 80'(stk_unf), 80'd1);
        check("R8", "exchange with empty tags", 80'(tag_word), 80'h3FFF);
    endtask

    task automatic t_ignore();
        do_cmd(4'd9, 3'd0, '0);
        check("R14", "ready low in clear", 80'(cmd_ready), 80'd0);
        do_cmd(4'd1, 3'd0, V_A);
        check("R14", "ignored push top", 80'(top_ptr), 80'd0);
        check("R14", "ignored push tags", 80'(tag_word), 80'hFFFF);
        check("R14", "ready back", 80'(cmd_ready), 80'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_push();
        t_store();
        t_xchg_pop();
        t_write_free_step();
        t_classify();
        t_wrap();
        t_overflow();
        t_underflow();
        t_ignore();
        finish_run();
    end
endmodule